// File: doc/BRIEF.md
# ROM-to-FIFO Write Sequencer

This block walks a combinational lookup memory from its first word to its last and hands each word to the write port of a clock-crossing FIFO. The memory's data output is wired straight to the FIFO data input. The sequencer therefore drives only two things: the memory address and the FIFO write request. It raises the request for one cycle per word and then spends one cycle stepping the address.

When the FIFO reports that it is full, the sequencer parks on the current address. It resumes on the first edge after the full flag clears, so the parked word is the next one written. After the word at the all-ones address has been written, the sequencer stops for good. Only a reset can start a new transfer.

All registers in the block reset synchronously to the write clock.

Top module: `rom_fifo_feeder`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `rom_addr` = 0 and `fifo_wr_req` low.
- R2: After reset, the block keeps `fifo_wr_req` low and `rom_addr` at 0 for as long as `fifo_full` is high. On the first edge that samples `fifo_full` low, it asserts `fifo_wr_req` with `rom_addr` = 0.
- R3: In any cycle with `fifo_wr_req` high, `rom_addr` equals its value from the previous cycle.
- R4: After a write cycle whose address is not all-ones, the following cycle has `fifo_wr_req` low and `rom_addr` one greater.
- R5: `fifo_wr_req` rises only after an edge at which `fifo_full` was sampled low. In every cycle that does not follow a write cycle, `rom_addr` is unchanged, so a word parked during a full stall is the word written next.
- R6: Once the write at the all-ones address (2**ADDR_W-1) has been issued, `fifo_wr_req` never rises again and `rom_addr` stays all-ones until reset, whatever `fifo_full` does.
- R7: A complete transfer issues exactly 2**ADDR_W write requests, with addresses 0, 1, 2, ... in ascending order and none repeated.
- R8: `fifo_wr_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_full | input | 1 | FIFO full flag; stalls the sequence while high |
| rom_addr | output | ADDR_W | Address presented to the lookup memory |
| fifo_wr_req | output | 1 | FIFO write request, one cycle per word |

## Verification
Each kind of wrong internal state shows up at the ports within one or two cycles:

- **Stray state change:** appears as a write request on the edge right after a full cycle, or as two requests back to back.
- **Address step lost or doubled:** appears on the cycle after the affected write, as an address that is not one greater.
- **Premature termination:** the transfer ends before reaching the all-ones word, so the write count stops short.
- **Missed termination:** a further request appears after the all-ones word.

The sweeps run full transfers under several back-pressure densities and one reset in mid-transfer. Every address is therefore written under both free and stalled conditions.

// File: rtl/rfw_pkg.sv
package rfw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_STEP  = 3'd2,
    ST_PARK  = 3'd3,
    ST_DONE  = 3'd4
  } feed_state_e;

endpackage

// File: rtl/rfw_addr_ctr.sv
module rfw_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic is_last(input logic [ADDR_W-1:0] a);
    return a == LAST_ADDR;
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (step) addr_q <= next_addr(addr_q);
  end

  assign addr    = addr_q;
  assign at_last = is_last(addr_q);

endmodule

// File: rtl/rfw_seq_fsm.sv
module rfw_seq_fsm
  import rfw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        full,
  input  logic        at_last,
  output feed_state_e state,
  output logic        wr_req,
  output logic        step_addr
);

  feed_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  state_d = full ? ST_IDLE : ST_WRITE;
      ST_WRITE: state_d = at_last ? ST_DONE : ST_STEP;
      ST_STEP:  state_d = full ? ST_PARK : ST_WRITE;
      ST_PARK:  state_d = full ? ST_PARK : ST_WRITE;
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state     = state_q;
  assign wr_req    = (state_q == ST_WRITE);
  assign step_addr = wr_req && !at_last;

endmodule

// File: rtl/rom_fifo_feeder.sv
module rom_fifo_feeder #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_full,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              fifo_wr_req
);

  import rfw_pkg::*;

  feed_state_e state;
  logic        at_last;
  logic        step_addr;
  logic        wr_req;

  rfw_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .full      (fifo_full),
    .at_last   (at_last),
    .state     (state),
    .wr_req    (wr_req),
    .step_addr (step_addr)
  );

  rfw_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .step    (step_addr),
    .addr    (rom_addr),
    .at_last (at_last)
  );

  assign fifo_wr_req = wr_req;

endmodule

// File: rtl/rom_fifo_feeder_chk.sv
module rom_fifo_feeder_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_full,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              fifo_wr_req,
  input logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic finished_q;

  always_ff @(posedge clk) begin
    if (rst)                                          finished_q <= 1'b0;
    else if (fifo_wr_req && (rom_addr == LAST_ADDR))  finished_q <= 1'b1;
  end

  // R8
  wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_req |=> !fifo_wr_req);

  // R5
  wr_after_free_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_req |-> !$past(fifo_full));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_wr_req) |-> $stable(rom_addr));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr_req && !at_last) |=> (!fifo_wr_req &&
      rom_addr == ADDR_W'($past(rom_addr) + 1'b1)));

  // R6
  no_req_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    finished_q |-> !fifo_wr_req);

  // R6
  end_addr_chk: assert property (@(posedge clk) disable iff (rst)
    finished_q |-> (rom_addr == LAST_ADDR));

endmodule

bind rom_fifo_feeder rom_fifo_feeder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .fifo_full   (fifo_full),
  .rom_addr    (rom_addr),
  .fifo_wr_req (fifo_wr_req),
  .at_last     (at_last)
);

// File: tb/rom_fifo_feeder_tb_top.sv
module rom_fifo_feeder_tb_top;

  localparam int AW    = 8;
  localparam int WORDS = 1 << AW;
  localparam int LAST  = WORDS - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_full = 1'b0;
  logic [AW-1:0] rom_addr;
  logic          fifo_wr_req;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  rom_fifo_feeder #(.ADDR_W(AW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .fifo_full   (fifo_full),
    .rom_addr    (rom_addr),
    .fifo_wr_req (fifo_wr_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    check(rom_addr == '0, "R1 addr", int'(rom_addr), 0);
    check(!fifo_wr_req, "R1 req", int'(fifo_wr_req), 0);
    rst = 1'b0;
  endtask

  task automatic run_pass(input int density, input int stop_after);
    int prev_addr = 0;
    bit prev_wr   = 1'b0;
    bit prev_full;
    int nwr  = 0;
    int tail = 0;
    int cyc  = 0;
    do_reset();
    fifo_full = ($urandom_range(99) < density);
    prev_full = fifo_full;
    while (tail < 20 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (fifo_wr_req) begin
        if (nwr >= WORDS) check(1'b0, "R6 extra req", nwr, WORDS);
        else check(int'(rom_addr) == nwr, "R7 order", int'(rom_addr), nwr);
        check(!prev_full, "R5 req after full", int'(prev_full), 0);
        check(!prev_wr, "R8 back-to-back", int'(prev_wr), 0);
        check(int'(rom_addr) == prev_addr, "R3 addr stable", int'(rom_addr), prev_addr);
        nwr++;
      end
      if (prev_wr && prev_addr != LAST) begin
        check(!fifo_wr_req, "R4 req low", int'(fifo_wr_req), 0);
        check(int'(rom_addr) == prev_addr + 1, "R4 step", int'(rom_addr), prev_addr + 1);
      end else if (!prev_wr) begin
        check(int'(rom_addr) == prev_addr, "R5 hold", int'(rom_addr), prev_addr);
      end
      if (nwr == WORDS && !fifo_wr_req)
        check(int'(rom_addr) == LAST, "R6 end addr", int'(rom_addr), LAST);
      if (stop_after != 0 && nwr >= stop_after) break;
      if (nwr == WORDS) tail++;
      prev_wr   = fifo_wr_req;
      prev_addr = int'(rom_addr);
      fifo_full = ($urandom_range(99) < density);
      prev_full = fifo_full;
    end
    if (stop_after == 0) check(nwr == WORDS, "R7 count", nwr, WORDS);
  endtask

  initial begin
    // R2: hold full after reset, no request, address 0
    do_reset();
    fifo_full = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!fifo_wr_req, "R2 idle req", int'(fifo_wr_req), 0);
      check(rom_addr == '0, "R2 idle addr", int'(rom_addr), 0);
    end
    fifo_full = 1'b0;
    @(negedge clk);
    check(fifo_wr_req, "R2 first req", int'(fifo_wr_req), 1);
    check(rom_addr == '0, "R2 first addr", int'(rom_addr), 0);

    run_pass(0, 0);
    run_pass(30, 0);
    run_pass(60, 50);   // reset in mid-transfer, R1 re-checked next pass
    run_pass(60, 0);
    run_pass(90, 0);
    run_pass(100, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule